// File: doc/BRIEF.md
# Bridge Prefetchable Window Decoder

This block keeps the prefetchable memory window of a PCI-to-PCI style bridge and decides, for each memory address it is shown, whether the access crosses the bridge. The window has a 1 MB granule. Its lower edge is set by a 16-bit base register together with a 32-bit upper extension. Its upper edge is set by a 16-bit limit register together with its own 32-bit upper extension. Together these give 44 significant bits for each edge of a 64-bit address space.

Software programs the registers through a small configuration port. The port has three 32-bit words and per-byte write enables. Read data returns one cycle after the request.

The decode side is purely combinational. It takes address bits 63:20, a direction flag and the two command enables, and it produces a forward decision and a prefetch-allowed flag:

- **Downstream** traffic is claimed when it falls inside the window.
- **Upstream** traffic is passed on when it falls outside the window.
- Prefetching is never granted downstream. Upstream, a 2-bit control input decides it.

Top module: `pfwin_decoder`

## Requirements
- R1: After reset, word 0 reads 32'h0001_0001, and words 1 and 2 read 0. This means base and limit fields are 0 and both 64-bit indicator nibbles read 1.
- R2: `cfgRvalid` is high in exactly the cycle after a cycle with `cfgReq`=1 and `cfgWrite`=0, and low otherwise. `cfgRdata` is valid while it is high.
- R3: Word 0 holds base bits 31:20 in data bits 15:4 and limit bits 31:20 in data bits 31:20. A write changes only the bytes whose `cfgByteEn` bit is 1. Data bits 3:0 and 19:16 always read 4'h1, whatever is written.
- R4: The window start is inclusive. An address whose bits 63:20 equal {base upper, base field} is inside the window.
- R5: The window end is exclusive. An address whose bits 63:20 equal {limit upper, limit field} is outside the window, and one granule below it is inside.
- R6: Word 1 (base upper) and word 2 (limit upper) are fully writable per byte. They take part in the compare as address bits 63:32.
- R7: When the 44-bit base is greater than or equal to the 44-bit limit, no address is inside the window.
- R8: A downstream access (`decUpstream`=0) is forwarded exactly when it is inside the window and `memSpaceEn`=1.
- R9: An upstream access (`decUpstream`=1) is forwarded exactly when it is outside the window and `busMasterEn`=1.
- R10: `decPrefetchOk` is always 0 for downstream accesses.
- R11: For upstream accesses, `decPrefetchOk` is 1 exactly when the address is inside the window and `upPrefCtl` is not 2'b00.
- R12: Word 3 reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgReq | input | 1 | Configuration access request |
| cfgWrite | input | 1 | 1 = write, 0 = read |
| cfgAddr | input | 2 | Word index (0 base/limit, 1 base upper, 2 limit upper) |
| cfgByteEn | input | 4 | Byte write enables |
| cfgWdata | input | 32 | Write data |
| cfgRdata | output | 32 | Read data |
| cfgRvalid | output | 1 | Read data valid |
| decAddrHi | input | 44 | Address bits 63:20 to decode |
| decUpstream | input | 1 | 1 = upstream, 0 = downstream |
| memSpaceEn | input | 1 | Memory space enable |
| busMasterEn | input | 1 | Bus master enable |
| upPrefCtl | input | 2 | Upstream prefetch control |
| decForward | output | 1 | Access is forwarded |
| decPrefetchOk | output | 1 | Prefetch allowed |

## Verification
The bench sweeps each address one granule below, at, and just under both window edges. It does this for every combination of direction, both enables and all four prefetch-control codes. A design with swapped inclusive/exclusive edges would show up here by forwarding the limit address downstream or dropping the base address.

It also programs a window that straddles a 4 GB boundary, and an empty or inverted window. A compare that ignored the upper words, or that treated the window as wrapping, would then claim the wrong traffic.

Partial byte writes and writes to the read-only nibbles are read back. This exposes a lane mix-up or an indicator nibble that can be overwritten.

// File: rtl/pfwin_pkg.sv
package pfwin_pkg;
  typedef enum logic [1:0] {
    WORD_BASELIM = 2'd0,
    WORD_BASEUP  = 2'd1,
    WORD_LIMUP   = 2'd2,
    WORD_NONE    = 2'd3
  } cfgWord_e;

  localparam int CFG_BYTES = 4;
  localparam logic [3:0] IND64 = 4'h1;

  typedef struct packed {
    logic [CFG_BYTES-1:0] wrBaseLim;
    logic [CFG_BYTES-1:0] wrBaseUp;
    logic [CFG_BYTES-1:0] wrLimUp;
    logic                 rdEn;
    cfgWord_e             rdSel;
  } pfwinStrobes_t;
endpackage

// File: rtl/pfwin_ctrl.sv
module pfwin_ctrl
  import pfwin_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgReq,
  input  logic                 cfgWrite,
  input  logic [1:0]           cfgAddr,
  input  logic [CFG_BYTES-1:0] cfgByteEn,
  output pfwinStrobes_t        strb,
  output logic                 cfgRvalid
);
  cfgWord_e word;
  logic     wrEn;

  assign word = cfgWord_e'(cfgAddr);
  assign wrEn = cfgReq && cfgWrite;

  always_comb begin
    strb = '0;
    strb.rdEn  = cfgReq && !cfgWrite;
    strb.rdSel = word;
    if (wrEn) begin
      case (word)
        WORD_BASELIM: strb.wrBaseLim = cfgByteEn;
        WORD_BASEUP:  strb.wrBaseUp  = cfgByteEn;
        WORD_LIMUP:   strb.wrLimUp   = cfgByteEn;
        default:      ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgRvalid <= 1'b0;
    else       cfgRvalid <= strb.rdEn;
  end
endmodule

// File: rtl/pfwin_regs.sv
module pfwin_regs
  import pfwin_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CFG_W  = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pfwinStrobes_t        strb,
  input  logic [CFG_W-1:0]     cfgWdata,
  output logic [CFG_W-1:0]     cfgRdata,
  output logic [11:0]          baseFld,
  output logic [11:0]          limFld,
  output logic [ADDR_W-33:0]   baseUp,
  output logic [ADDR_W-33:0]   limUp
);
  localparam int UP_W     = ADDR_W - 32;
  localparam int UP_BYTES = UP_W / 8;

  // Word 0: base field in bits 15:4, limit field in bits 31:20
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseFld <= '0;
      limFld  <= '0;
    end else begin
      if (strb.wrBaseLim[0]) baseFld[3:0]  <= cfgWdata[7:4];
      if (strb.wrBaseLim[1]) baseFld[11:4] <= cfgWdata[15:8];
      if (strb.wrBaseLim[2]) limFld[3:0]   <= cfgWdata[23:20];
      if (strb.wrBaseLim[3]) limFld[11:4]  <= cfgWdata[31:24];
    end
  end

  for (genvar i = 0; i < UP_BYTES; i++) begin : g_upLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseUp[8*i +: 8] <= '0;
        limUp[8*i +: 8]  <= '0;
      end else begin
        if (strb.wrBaseUp[i]) baseUp[8*i +: 8] <= cfgWdata[8*i +: 8];
        if (strb.wrLimUp[i])  limUp[8*i +: 8]  <= cfgWdata[8*i +: 8];
      end
    end
  end

  logic [CFG_W-1:0] rdMux;
  always_comb begin
    case (strb.rdSel)
      WORD_BASELIM: rdMux = {limFld, IND64, baseFld, IND64};
      WORD_BASEUP:  rdMux = baseUp;
      WORD_LIMUP:   rdMux = limUp;
      default:      rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cfgRdata <= '0;
    else if (strb.rdEn) cfgRdata <= rdMux;
  end
endmodule

// File: rtl/pfwin_match.sv
module pfwin_match #(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-21:0] addrHi,
  input  logic [11:0]        baseFld,
  input  logic [11:0]        limFld,
  input  logic [ADDR_W-33:0] baseUp,
  input  logic [ADDR_W-33:0] limUp,
  input  logic               upstream,
  input  logic               memEn,
  input  logic               bmEn,
  input  logic [1:0]         prefCtl,
  output logic               forward,
  output logic               prefOk
);
  localparam int CMP_W = ADDR_W - 20;

  logic [CMP_W-1:0] baseCmp, limCmp;
  logic             geBase, ltLim, inWin;

  assign baseCmp = {baseUp, baseFld};
  assign limCmp  = {limUp, limFld};
  assign geBase  = addrHi >= baseCmp;
  assign ltLim   = addrHi < limCmp;
  assign inWin   = geBase && ltLim;

  always_comb begin
    if (upstream) begin
      forward = !inWin && bmEn;
      prefOk  = inWin && (prefCtl != 2'b00);
    end else begin
      forward = inWin && memEn;
      prefOk  = 1'b0;
    end
  end
endmodule

// File: rtl/pfwin_decoder.sv
module pfwin_decoder
  import pfwin_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CFG_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgReq,
  input  logic               cfgWrite,
  input  logic [1:0]         cfgAddr,
  input  logic [3:0]         cfgByteEn,
  input  logic [CFG_W-1:0]   cfgWdata,
  output logic [CFG_W-1:0]   cfgRdata,
  output logic               cfgRvalid,
  input  logic [ADDR_W-21:0] decAddrHi,
  input  logic               decUpstream,
  input  logic               memSpaceEn,
  input  logic               busMasterEn,
  input  logic [1:0]         upPrefCtl,
  output logic               decForward,
  output logic               decPrefetchOk
);
  pfwinStrobes_t       strb;
  logic [11:0]         baseFld, limFld;
  logic [ADDR_W-33:0]  baseUp, limUp;

  pfwin_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cfgReq(cfgReq), .cfgWrite(cfgWrite),
    .cfgAddr(cfgAddr), .cfgByteEn(cfgByteEn), .strb(strb), .cfgRvalid(cfgRvalid)
  );

  pfwin_regs #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) i_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .baseFld(baseFld), .limFld(limFld), .baseUp(baseUp), .limUp(limUp)
  );

  pfwin_match #(.ADDR_W(ADDR_W)) i_match (
    .addrHi(decAddrHi), .baseFld(baseFld), .limFld(limFld), .baseUp(baseUp),
    .limUp(limUp), .upstream(decUpstream), .memEn(memSpaceEn), .bmEn(busMasterEn),
    .prefCtl(upPrefCtl), .forward(decForward), .prefOk(decPrefetchOk)
  );
endmodule

// File: rtl/pfwin_decoder_chk.sv
module pfwin_decoder_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cfgReq,
  input logic        cfgWrite,
  input logic [1:0]  cfgAddr,
  input logic [31:0] cfgRdata,
  input logic        cfgRvalid,
  input logic        decUpstream,
  input logic        memSpaceEn,
  input logic        busMasterEn,
  input logic [1:0]  upPrefCtl,
  input logic        decForward,
  input logic        decPrefetchOk
);
  a_r2_rvalid_follows_read: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReq && !cfgWrite) |=> cfgRvalid);
  a_r2_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgReq && !cfgWrite) |=> !cfgRvalid);
  a_r3_ro_nibbles: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRvalid && $past(cfgAddr) == 2'd0) |-> (cfgRdata[3:0] == 4'h1 && cfgRdata[19:16] == 4'h1));
  a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRvalid && $past(cfgAddr) == 2'd3) |-> cfgRdata == 32'h0);
  a_r8_needs_mem_en: assert property (@(posedge clk) disable iff (!rstN)
    (!decUpstream && !memSpaceEn) |-> !decForward);
  a_r9_needs_bus_master: assert property (@(posedge clk) disable iff (!rstN)
    (decUpstream && !busMasterEn) |-> !decForward);
  a_r9_hit_not_forwarded: assert property (@(posedge clk) disable iff (!rstN)
    (decUpstream && decPrefetchOk) |-> !decForward);
  a_r10_no_down_prefetch: assert property (@(posedge clk) disable iff (!rstN)
    !decUpstream |-> !decPrefetchOk);
  a_r11_ctrl_off: assert property (@(posedge clk) disable iff (!rstN)
    (decUpstream && upPrefCtl == 2'b00) |-> !decPrefetchOk);
endmodule

bind pfwin_decoder pfwin_decoder_chk i_chk (.*);

// File: tb/test_pfwin_decoder.sv
`timescale 1ns/1ps
module test_pfwin_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgReq = 1'b0, cfgWrite = 1'b0;
  logic [1:0]  cfgAddr = '0;
  logic [3:0]  cfgByteEn = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        cfgRvalid;
  logic [43:0] decAddrHi = '0;
  logic        decUpstream = 1'b0, memSpaceEn = 1'b0, busMasterEn = 1'b0;
  logic [1:0]  upPrefCtl = '0;
  logic        decForward, decPrefetchOk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [11:0] shBase = '0, shLim = '0;
  logic [31:0] shBaseUp = '0, shLimUp = '0;

  always #2.5 clk = ~clk;

  pfwin_decoder i_pfwin_decoder (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfgWr(input logic [1:0] w, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfgReq = 1; cfgWrite = 1; cfgAddr = w; cfgByteEn = be; cfgWdata = d;
    @(negedge clk);
    cfgReq = 0; cfgWrite = 0; cfgByteEn = '0;
    for (int b = 0; b < 4; b++) begin
      if (be[b]) begin
        if (w == 2'd1) shBaseUp[8*b +: 8] = d[8*b +: 8];
        if (w == 2'd2) shLimUp[8*b +: 8]  = d[8*b +: 8];
      end
    end
    if (w == 2'd0) begin
      if (be[0]) shBase[3:0]  = d[7:4];
      if (be[1]) shBase[11:4] = d[15:8];
      if (be[2]) shLim[3:0]   = d[23:20];
      if (be[3]) shLim[11:4]  = d[31:24];
    end
  endtask

  function automatic logic [31:0] expWord(input logic [1:0] w);
    case (w)
      2'd0: return {shLim, 4'h1, shBase, 4'h1};
      2'd1: return shBaseUp;
      2'd2: return shLimUp;
      default: return 32'h0;
    endcase
  endfunction

  task automatic cfgRd(input logic [1:0] w, input string tag);
    @(negedge clk);
    cfgReq = 1; cfgWrite = 0; cfgAddr = w;
    @(negedge clk);
    cfgReq = 0;
    chk({tag, " R2 rvalid"}, {31'b0, cfgRvalid}, 32'h1);
    chk(tag, cfgRdata, expWord(w));
    @(negedge clk);
    chk("R2 rvalid drop", {31'b0, cfgRvalid}, 32'h0);
  endtask

  function automatic logic expHit(input logic [43:0] a);
    logic [43:0] b, l;
    b = {shBaseUp, shBase};
    l = {shLimUp, shLim};
    return (a >= b) && (a < l);
  endfunction

  task automatic sweep(input logic [43:0] a, input string tag);
    logic eh, ef, ep;
    decAddrHi = a;
    eh = expHit(a);
    for (int dir = 0; dir < 2; dir++)
      for (int me = 0; me < 2; me++)
        for (int bm = 0; bm < 2; bm++)
          for (int pc = 0; pc < 4; pc++) begin
            decUpstream = dir[0]; memSpaceEn = me[0]; busMasterEn = bm[0];
            upPrefCtl = pc[1:0];
            #0.1;
            ef = dir[0] ? (!eh && bm[0]) : (eh && me[0]);
            ep = dir[0] && eh && (pc != 0);
            chk($sformatf("%s %s fwd a=%h", tag, dir[0] ? "R9" : "R8", a), {31'b0, decForward}, {31'b0, ef});
            chk($sformatf("%s %s pref a=%h", tag, dir[0] ? "R11" : "R10", a), {31'b0, decPrefetchOk}, {31'b0, ep});
          end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #12 rstN = 1;
    // R1 reset state
    cfgRd(2'd0, "R1 word0");
    cfgRd(2'd1, "R1 word1");
    cfgRd(2'd2, "R1 word2");
    sweep(44'h0, "R7 reset empty");

    // R3 partial byte writes, read-only nibbles
    cfgWr(2'd0, 4'b0001, 32'hFFFF_FF50);
    cfgRd(2'd0, "R3 byte0");
    cfgWr(2'd0, 4'b1000, 32'hA7A0_0000);
    cfgRd(2'd0, "R3 byte3");
    cfgWr(2'd0, 4'b0110, 32'h00E0_2300);
    cfgRd(2'd0, "R3 bytes12");

    // R6 upper words per byte
    cfgWr(2'd1, 4'b0101, 32'h1122_3344);
    cfgRd(2'd1, "R6 baseup");
    cfgWr(2'd2, 4'b1010, 32'h5566_7788);
    cfgRd(2'd2, "R6 limup");

    // R12 unmapped word
    cfgWr(2'd3, 4'b1111, 32'hFFFF_FFFF);
    cfgRd(2'd3, "R12 word3");
    cfgRd(2'd0, "R12 word0 intact");
    cfgRd(2'd1, "R12 word1 intact");

    // Window 1: 0x100..0x200 granules, low 4 GB
    cfgWr(2'd1, 4'hF, 32'h0);
    cfgWr(2'd2, 4'hF, 32'h0);
    cfgWr(2'd0, 4'hF, 32'h2000_1000);
    sweep(44'h0FF, "R4 below base");
    sweep(44'h100, "R4 at base");
    sweep(44'h180, "R4 mid");
    sweep(44'h1FF, "R5 last granule");
    sweep(44'h200, "R5 at limit");
    sweep(44'h1_100, "R6 upper set");

    // Window 2: straddles a 4 GB boundary
    cfgWr(2'd1, 4'hF, 32'h1);
    cfgWr(2'd2, 4'hF, 32'h2);
    cfgWr(2'd0, 4'hF, 32'h0010_FFF0);
    cfgRd(2'd0, "R3 window2");
    sweep(44'h1_FFE, "R6 below base");
    sweep(44'h1_FFF, "R6 at base");
    sweep(44'h2_000, "R6 across 4G");
    sweep(44'h2_000 + 44'h0, "R5 inside");
    sweep(44'h2_001, "R5 at limit");
    sweep(44'h0_FFF, "R6 low word only");

    // Window 3/4: empty and inverted
    cfgWr(2'd1, 4'hF, 32'h0);
    cfgWr(2'd2, 4'hF, 32'h0);
    cfgWr(2'd0, 4'hF, 32'h3000_3000);
    sweep(44'h300, "R7 equal");
    sweep(44'h2FF, "R7 equal below");
    cfgWr(2'd0, 4'hF, 32'h2000_4000);
    sweep(44'h300, "R7 inverted");
    sweep(44'h400, "R7 inverted base");
    sweep(44'h1FF, "R7 inverted low");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule